// File: doc/BRIEF.md
# Page-Mode Burst Cycle Sequencer

This block turns a burst request from a DMA engine into a timed sequence of word strobes toward a DRAM-style memory and adds up how many system cycles the burst takes. A request carries a byte start address and a word count. Every word takes exactly one clock and gets one strobe. The address moves forward one 32-bit word (4 bytes) per strobe. A new row must be opened before each group of sixteen words, and that costs one extra cycle with no strobe. A group that is only partly filled still pays this cycle. A burst of N words therefore costs N + floor((N + 15) / 16) cycles. That total appears on `cycles_o` in the same cycle as a one-cycle `done_o` pulse.

A second kind of request models one plain processor access to the same memory. It holds the block for a base cycle plus a number of waitstates, both set by parameters (1 + 6 = 7 cycles by default). It issues one strobe in its final cycle and reports that cost.

The controller is a five-state machine:
- `S_IDLE` waits for a start.
- `S_ROWLD` is the row-open cycle.
- `S_XFER` carries one word per cycle.
- `S_WAIT` times the single access.
- `S_FINISH` raises the done pulse.

The state transitions are:
- IDLE→WAIT on a single start.
- IDLE→FINISH on a burst start with zero words.
- IDLE→ROWLD on any other burst start.
- ROWLD→XFER always.
- XFER→FINISH after the last word.
- XFER→ROWLD after the sixteenth word of a group when more words remain.
- XFER→XFER otherwise.
- WAIT→FINISH when the wait counter reaches zero.
- FINISH→IDLE always.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, `busy_o`, `strobe_o`, `row_load_o` and `done_o` are low and `cycles_o` is zero.
- R2: A burst of N>0 words issues exactly N strobes, one per clock, and keeps the block busy for N + floor((N+15)/16) cycles before the done cycle.
- R3: A row-load cycle (`row_load_o` high, no strobe) comes first in a burst and before every later group of sixteen words.
- R4: The first strobe of a burst carries `addr_i`. Each later strobe carries the previous address plus 4, wrapping modulo 2^ADDR_W.
- R5: `done_o` is high for exactly one cycle, in the cycle after the last costed cycle. In that cycle `cycles_o` equals N + floor((N+15)/16) for a burst of N words.
- R6: A burst with a count of zero raises `done_o` in the cycle after the start with `cycles_o` equal to 0, and produces no strobe and no row load.
- R7: A start that arrives while `busy_o` is high, including during the done cycle, is ignored. It adds no strobe, and the block is idle in the cycle after the done pulse.
- R8: A start with `single_i` high ignores `count_i`. It keeps the block busy for SINGLE_BASE + SINGLE_WAIT cycles (7 by default) with no row load, strobes `addr_i` once in the last of them, and reports that count on `cycles_o`.
- R9: `row_load_o` and `strobe_o` are never high in the same cycle, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request start, taken only when idle |
| single_i | input | 1 | 1: single processor access; 0: burst |
| addr_i | input | ADDR_W | Byte start address |
| count_i | input | CNT_W | Words in the burst |
| busy_o | output | 1 | High from acceptance through the done cycle |
| row_load_o | output | 1 | Row-open cycle in progress |
| strobe_o | output | 1 | One data word is transferred this cycle |
| addr_o | output | ADDR_W | Address of the current word |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | CNT_W+1 | Cycles consumed by the finished request |

## Verification
The assertions take for granted that `start_i` is only ever acted on while the block is idle. They also assume that `count_i`, `single_i` and `addr_i` are meaningful only at the edge where a start is accepted, and that the count stays within CNT_W bits. The stimulus drives inputs on the falling edge and holds `start_i` for a single cycle for each real request. It changes the request fields only together with a start pulse. It deliberately raises extra starts only while the block is busy, so that their effect, or lack of it, shows up in the strobe stream the scoreboard compares.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROWLD,
        S_XFER,
        S_WAIT,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/burst_seq_words.sv
module burst_seq_words #(
    parameter int CNT_W = 16,
    parameter int GROUP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    output logic             last_word,
    output logic             group_end
);
    localparam int GRP_W = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP - 1);

    logic [CNT_W-1:0] remaining;
    logic [GRP_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            slot      <= '0;
        end else if (load) begin
            remaining <= count;
            slot      <= '0;
        end else if (step) begin
            remaining <= remaining - 1'b1;
            slot      <= (slot == GRP_LAST) ? '0 : slot + 1'b1;
        end
    end

    assign last_word = (remaining == CNT_W'(1));
    assign group_end = (slot == GRP_LAST);

endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr #(
    parameter int ADDR_W     = 24,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step)
            addr <= addr + STRIDE;
    end

endmodule

// File: rtl/burst_seq_acct.sv
module burst_seq_acct #(
    parameter int TOT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [TOT_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            total <= '0;
        else if (clear)
            total <= '0;
        else if (tick)
            total <= total + 1'b1;
    end

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int CNT_W       = 16,
    parameter int GROUP       = 16,
    parameter int WORD_BYTES  = 4,
    parameter int SINGLE_BASE = 1,
    parameter int SINGLE_WAIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              single_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              row_load_o,
    output logic              strobe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic [CNT_W:0]    cycles_o
);
    localparam int TOT_W       = CNT_W + 1;
    localparam int SINGLE_COST = SINGLE_BASE + SINGLE_WAIT;
    localparam int WAIT_W      = (SINGLE_COST > 1) ? $clog2(SINGLE_COST) : 1;

    seq_state_e  state, state_nx;
    logic [WAIT_W-1:0] wait_cnt;
    logic accept, last_word, group_end, in_xfer, tick;

    assign accept = start_i && (state == S_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // single-access wait counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if (accept)
            wait_cnt <= WAIT_W'(SINGLE_COST - 1);
        else if (state == S_WAIT && wait_cnt != '0)
            wait_cnt <= wait_cnt - 1'b1;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (single_i)
                        state_nx = S_WAIT;
                    else if (count_i == '0)
                        state_nx = S_FINISH;
                    else
                        state_nx = S_ROWLD;
                end
            end
            S_ROWLD:  state_nx = S_XFER;
            S_XFER: begin
                if (last_word)
                    state_nx = S_FINISH;
                else if (group_end)
                    state_nx = S_ROWLD;
                else
                    state_nx = S_XFER;
            end
            S_WAIT:   state_nx = (wait_cnt == '0) ? S_FINISH : S_WAIT;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        busy_o     = 1'b1;
        row_load_o = 1'b0;
        strobe_o   = 1'b0;
        done_o     = 1'b0;
        unique case (state)
            S_IDLE:   busy_o     = 1'b0;
            S_ROWLD:  row_load_o = 1'b1;
            S_XFER:   strobe_o   = 1'b1;
            S_WAIT:   strobe_o   = (wait_cnt == '0);
            S_FINISH: done_o     = 1'b1;
            default:  busy_o     = 1'b0;
        endcase
    end

    assign in_xfer = (state == S_XFER);
    assign tick    = (state == S_ROWLD) || (state == S_XFER) || (state == S_WAIT);

    burst_seq_words #(
        .CNT_W (CNT_W),
        .GROUP (GROUP)
    ) u_words (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .count     (count_i),
        .step      (in_xfer),
        .last_word (last_word),
        .group_end (group_end)
    );

    burst_seq_addr #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .base  (addr_i),
        .step  (in_xfer),
        .addr  (addr_o)
    );

    burst_seq_acct #(
        .TOT_W (TOT_W)
    ) u_acct (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick),
        .total (cycles_o)
    );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              single_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              busy_o,
    input logic              row_load_o,
    input logic              strobe_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              done_o,
    input logic [CNT_W:0]    cycles_o
);
    AST_ROW_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_load_o && strobe_o)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!strobe_o && !row_load_o && !done_o)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && $past(strobe_o)) |-> (addr_o == $past(addr_o) + ADDR_W'(4))); // R4

    AST_ROW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !single_i && count_i != '0) |=> row_load_o); // R3

    AST_ZERO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !single_i && count_i == '0) |=> (done_o && cycles_o == '0)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R7

    AST_ROW_THEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        row_load_o |=> strobe_o); // R3

endmodule

bind burst_seq_top burst_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .single_i   (single_i),
    .count_i    (count_i),
    .busy_o     (busy_o),
    .row_load_o (row_load_o),
    .strobe_o   (strobe_o),
    .addr_o     (addr_o),
    .done_o     (done_o),
    .cycles_o   (cycles_o)
);

// File: tb/burst_seq_top_bench.sv
`timescale 1ns/1ps
module burst_seq_top_bench;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int SCOST  = 7;
    localparam int unsigned AMASK = 32'h00FF_FFFF;
    localparam int K_ROW = 1, K_STB = 2, K_DONE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic single_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [CNT_W-1:0]  count_i = '0;
    logic busy_o, row_load_o, strobe_o, done_o;
    logic [ADDR_W-1:0] addr_o;
    logic [CNT_W:0]    cycles_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int          q_kind[$];
    int unsigned q_val[$];
    string       q_req[$];

    always #2 clk = ~clk;

    burst_seq_top u_burst_seq_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .single_i(single_i),
        .addr_i(addr_i), .count_i(count_i), .busy_o(busy_o),
        .row_load_o(row_load_o), .strobe_o(strobe_o), .addr_o(addr_o),
        .done_o(done_o), .cycles_o(cycles_o)
    );

    task automatic check(input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int k, input int unsigned v, input string r);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_req.push_back(r);
    endtask

    task automatic pop_cmp(input int k, input int unsigned v);
        int ek;
        int unsigned ev;
        string er;
        if (q_kind.size() == 0) begin
            check("R7", "unexpected event kind", k, 0);
        end else begin
            ek = q_kind.pop_front();
            ev = q_val.pop_front();
            er = q_req.pop_front();
            check(er, "event kind", k, ek);
            if (k == ek) check(er, "event value", v, ev);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (row_load_o) pop_cmp(K_ROW, 0);
            if (strobe_o)   pop_cmp(K_STB, int'(addr_o));
            if (done_o)     pop_cmp(K_DONE, int'(cycles_o));
        end
    end

    task automatic do_op(input bit sgl, input int unsigned a, input int unsigned n,
                         input bit poke_busy, input bit poke_done);
        int unsigned tot;
        int unsigned lat;
        string rq;
        if (sgl) begin
            push(K_STB, a & AMASK, "R8");
            tot = SCOST;
            push(K_DONE, tot, "R8");
            rq = "R8";
        end else begin
            for (int i = 0; i < int'(n); i++) begin
                if (i % 16 == 0) push(K_ROW, 0, "R3");
                push(K_STB, (a + 4 * i) & AMASK, "R4");
            end
            tot = n + (n + 15) / 16;
            push(K_DONE, tot, (n == 0) ? "R6" : "R5");
            rq = (n == 0) ? "R6" : "R2";
        end
        @(negedge clk);
        start_i  = 1'b1;
        single_i = sgl;
        addr_i   = a[ADDR_W-1:0];
        count_i  = n[CNT_W-1:0];
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100000) begin
            if (poke_busy && lat == 3) begin
                start_i  = 1'b1;   // R7: must be ignored
                single_i = 1'b0;
                addr_i   = 24'h00_0040;
                count_i  = 16'd3;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(rq, "done latency", lat, tot + 1);
        if (poke_done) begin
            start_i  = 1'b1;       // R7: start in the done cycle
            single_i = 1'b0;
            count_i  = 16'd2;
            @(negedge clk);
            start_i = 1'b0;
            check("R7", "busy after done", busy_o, 0);
        end
        repeat (3) @(negedge clk);
        check("R2", "leftover events", q_kind.size(), 0);
    endtask

    task automatic finish_run;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", busy_o, 0);
        check("R1", "strobe", strobe_o, 0);
        check("R1", "row_load", row_load_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "cycles", cycles_o, 0);

        do_op(1'b0, 32'h100, 1, 1'b0, 1'b0);          // R2 single word
        do_op(1'b0, 32'h2000, 16, 1'b0, 1'b0);        // R3 full group
        do_op(1'b0, 32'h3000, 17, 1'b0, 1'b0);        // R3 second group
        do_op(1'b0, 32'hFF_FFF8, 33, 1'b0, 1'b0);     // R4 wrap
        do_op(1'b0, 32'h500, 0, 1'b0, 1'b0);          // R6 zero
        do_op(1'b1, 32'h1234, 9, 1'b0, 1'b0);         // R8 single access
        do_op(1'b0, 32'h8000, 40, 1'b1, 1'b0);        // R7 start while busy
        do_op(1'b0, 32'h9000, 5, 1'b0, 1'b1);         // R7 start at done
        do_op(1'b1, 32'hABC0, 0, 1'b1, 1'b1);         // R8 with pokes
        do_op(1'b0, 32'h4, 48, 1'b0, 1'b0);           // R5 exact groups
        finish_run();
    end

endmodule